// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a small, fully associative address translation cache. Software fills and replaces it. Each slot maps a pair of neighbouring virtual pages: an even page and an odd page. A slot holds four things. The first is a tag: a 2-bit region, a virtual page-pair number and an 8-bit address-space tag. The second is a page-size mask. The other two are one descriptor per half, each with a frame number, a 3-bit cache attribute, a writable (dirty) flag, a valid flag and a global flag. Table walking and victim choice stay in software, which writes whole slots through an indexed write port.

The lookup port accepts a 64-bit virtual address, the current address-space tag and a store flag. One cycle later it returns one of two results. On success it gives a 36-bit physical address and a cache attribute. Otherwise it gives a status code for one of three faults: no matching slot, matching slot with the chosen half marked not valid, or store to a half whose writable flag is clear. A probe port takes a tag word and returns the index of the matching slot, or a not-found flag, one cycle later.

Top module: `pair_tlb`

## Requirements
- R1: After reset every slot holds all-zero words and all outputs are low. A lookup at address 0 with tag 0 then reports status 2 (invalid), and any address outside page pair 0 reports status 1 (miss).
- R2: `lk_valid` is high in exactly the cycle after a cycle with `lk_req` high. The status, address, attribute and index registers load only on a request.
- R3: A slot matches when three conditions hold. Address bits 63:62 equal the stored region. Address bits 39:13 equal the stored page-pair number, except at masked positions. The tag in bits 7:0 of the stored word equals the request tag, unless the slot is global. A slot is global only when bit 0 is set in both of its descriptor words.
- R4: Without a mask, address bit 12 selects the half: 0 picks descriptor word 0 and 1 picks descriptor word 1.
- R5: Page-mask bit i removes address bit 13+i from the compare. Set mask bits must be contiguous from bit 0. The half-select bit then moves up to address bit 12+k, where k is the number of set mask bits. Address bits below 12+k pass straight into the physical address.
- R6: On a success, the physical address is the frame number (descriptor bits 29:6) shifted left by 12, ORed with the page-offset bits of the virtual address. The attribute is descriptor bits 5:3. Descriptor bits 31:30 have no effect.
- R7: Status codes are 0 for success, 1 for miss, 2 for a clear valid flag (descriptor bit 1) and 3 for a store to a half whose writable flag (descriptor bit 2) is clear. A load to such a half succeeds. Every code other than 0 drives the address and the attribute to zero.
- R8: When several slots match, the lowest index wins and is reported on `lk_index`. On a miss the index reads 0.
- R9: A probe answers in the cycle after `pr_req`, using the same match rule without regard to the valid flags. The result is the lowest matching index with bit 3 clear, or the value 8 (bit 3 set) when nothing matches.
- R10: A write stores the slot addressed by `wr_index` at the clock edge. A lookup made in the same cycle as the write still sees the old contents, and a lookup in the next cycle sees the new ones.
- R11: Address bits 61:40 and tag-word bits 12:8 play no part in matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write the slot at `wr_index` |
| wr_index | input | 3 | Slot to write |
| wr_hi | input | 64 | Tag word: region 63:62, page pair 39:13, address-space tag 7:0 |
| wr_mask | input | 4 | Page mask; bit i covers address bit 13+i |
| wr_lo0 | input | 32 | Even-half descriptor |
| wr_lo1 | input | 32 | Odd-half descriptor |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_store | input | 1 | Access is a store |
| lk_valid | output | 1 | Lookup result valid |
| lk_status | output | 2 | 0 success, 1 miss, 2 invalid, 3 store to clean page |
| lk_pa | output | 36 | Physical address |
| lk_cattr | output | 3 | Cache attribute |
| lk_index | output | 3 | Index of the winning slot |
| pr_req | input | 1 | Probe request |
| pr_hi | input | 64 | Probe tag word, same layout as `wr_hi` |
| pr_valid | output | 1 | Probe result valid |
| pr_result | output | 4 | Matching index, or bit 3 set for none |

## Verification
A corrupted slot cannot hide. On the first lookup that touches it, the error shows up at the ports within one cycle, as a wrong status code, a wrong frame in `lk_pa` or a wrong winning index. A wrong half-select or mask state changes the frame or the offset bits that reach the physical address. A fault on the global or writable flag turns a success into a miss or a store fault. The bench therefore keeps a model of every slot and checks each lookup and probe one cycle after the request, including lookups issued in the same cycle as a write.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  localparam int VA_W       = 64;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_MSB    = 39;
  localparam int VPN2_LSB   = PAGE_SHIFT + 1;
  localparam int VPN2_W     = VPN_MSB - VPN2_LSB + 1;
  localparam int MASK_W     = 4;
  localparam int ASID_W     = 8;
  localparam int LO_W       = 32;
  localparam int PFN_LSB    = 6;
  localparam int PFN_MSB    = 29;
  localparam int PFN_W      = PFN_MSB - PFN_LSB + 1;
  localparam int PA_W       = PFN_W + PAGE_SHIFT;

  typedef enum logic [1:0] {
    ST_HIT     = 2'd0,
    ST_MISS    = 2'd1,
    ST_INVALID = 2'd2,
    ST_MODIFY  = 2'd3
  } lk_status_e;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [2:0]       cattr;
    logic             dirty;
    logic             valid;
  } half_t;

  typedef struct packed {
    logic [1:0]        region;
    logic [VPN2_W-1:0] vpn2;
    logic [ASID_W-1:0] asid;
    logic [MASK_W-1:0] mask;
    logic              glob;
    half_t             even;
    half_t             odd;
  } slot_t;
endpackage

// File: rtl/pair_tlb_match.sv
module pair_tlb_match
  import pair_tlb_pkg::*;
(
  input  logic [1:0]        ent_region,
  input  logic [VPN2_W-1:0] ent_vpn2,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [MASK_W-1:0] ent_mask,
  input  logic              ent_glob,
  input  logic [1:0]        req_region,
  input  logic [VPN2_W-1:0] req_vpn2,
  input  logic [ASID_W-1:0] req_asid,
  output logic              hit
);
  logic [VPN2_W-1:0] cmp_en;
  logic              region_eq;
  logic              vpn_eq;
  logic              asid_eq;

  always_comb begin
    cmp_en    = ~{{(VPN2_W-MASK_W){1'b0}}, ent_mask};
    region_eq = (ent_region == req_region);
    vpn_eq    = (((ent_vpn2 ^ req_vpn2) & cmp_en) == '0);
    asid_eq   = ent_glob || (ent_asid == req_asid);
    hit       = region_eq && vpn_eq && asid_eq;
  end
endmodule

// File: rtl/pair_tlb_prienc.sv
module pair_tlb_prienc #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VA_W-1:0]   wr_hi,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [LO_W-1:0]   wr_lo0,
  input  logic [LO_W-1:0]   wr_lo1,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  output logic              lk_valid,
  output logic [1:0]        lk_status,
  output logic [PA_W-1:0]   lk_pa,
  output logic [2:0]        lk_cattr,
  output logic [IDX_W-1:0]  lk_index,
  input  logic              pr_req,
  input  logic [VA_W-1:0]   pr_hi,
  output logic              pr_valid,
  output logic [IDX_W:0]    pr_result
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // bits kept out of storage and compare
  logic unused_bits;
  assign unused_bits = ^{wr_hi[61:VPN_MSB+1], wr_hi[VPN2_LSB-1:ASID_W],
                         wr_lo0[LO_W-1:PFN_MSB+1], wr_lo1[LO_W-1:PFN_MSB+1],
                         lk_va[61:VPN_MSB+1], pr_hi[61:VPN_MSB+1],
                         pr_hi[VPN2_LSB-1:ASID_W]};

  // slot storage
  slot_t slot_q [N_ENT];
  slot_t wr_slot;

  always_comb begin
    wr_slot.region      = wr_hi[VA_W-1 -: 2];
    wr_slot.vpn2        = wr_hi[VPN_MSB:VPN2_LSB];
    wr_slot.asid        = wr_hi[ASID_W-1:0];
    wr_slot.mask        = wr_mask;
    wr_slot.glob        = wr_lo0[0] & wr_lo1[0];
    wr_slot.even.pfn    = wr_lo0[PFN_MSB:PFN_LSB];
    wr_slot.even.cattr  = wr_lo0[5:3];
    wr_slot.even.dirty  = wr_lo0[2];
    wr_slot.even.valid  = wr_lo0[1];
    wr_slot.odd.pfn     = wr_lo1[PFN_MSB:PFN_LSB];
    wr_slot.odd.cattr   = wr_lo1[5:3];
    wr_slot.odd.dirty   = wr_lo1[2];
    wr_slot.odd.valid   = wr_lo1[1];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < N_ENT; i++) slot_q[i] <= '0;
    end else if (wr_en) begin
      slot_q[wr_index] <= wr_slot;
    end
  end

  // parallel compare, lookup and probe
  logic [N_ENT-1:0] lk_vec;
  logic [N_ENT-1:0] pr_vec;

  for (genvar e = 0; e < N_ENT; e++) begin : g_slot
    pair_tlb_match u_lk_match (
      .ent_region (slot_q[e].region),
      .ent_vpn2   (slot_q[e].vpn2),
      .ent_asid   (slot_q[e].asid),
      .ent_mask   (slot_q[e].mask),
      .ent_glob   (slot_q[e].glob),
      .req_region (lk_va[VA_W-1 -: 2]),
      .req_vpn2   (lk_va[VPN_MSB:VPN2_LSB]),
      .req_asid   (lk_asid),
      .hit        (lk_vec[e])
    );
    pair_tlb_match u_pr_match (
      .ent_region (slot_q[e].region),
      .ent_vpn2   (slot_q[e].vpn2),
      .ent_asid   (slot_q[e].asid),
      .ent_mask   (slot_q[e].mask),
      .ent_glob   (slot_q[e].glob),
      .req_region (pr_hi[VA_W-1 -: 2]),
      .req_vpn2   (pr_hi[VPN_MSB:VPN2_LSB]),
      .req_asid   (pr_hi[ASID_W-1:0]),
      .hit        (pr_vec[e])
    );
  end

  logic [IDX_W-1:0] lk_idx;
  logic             lk_any;
  logic [IDX_W-1:0] pr_idx;
  logic             pr_any;

  pair_tlb_prienc #(.N(N_ENT), .IDX_W(IDX_W)) u_lk_enc (
    .vec (lk_vec), .idx (lk_idx), .any (lk_any)
  );
  pair_tlb_prienc #(.N(N_ENT), .IDX_W(IDX_W)) u_pr_enc (
    .vec (pr_vec), .idx (pr_idx), .any (pr_any)
  );

  // half select, address formation, fault ranking
  slot_t             sel_slot;
  logic              sel_odd;
  half_t             half;
  logic [PA_W-1:0]   off_mask;
  logic [PA_W-1:0]   pa_raw;
  lk_status_e        status_d;
  logic [PA_W-1:0]   pa_d;
  logic [2:0]        cattr_d;
  logic [IDX_W:0]    pr_res_d;

  always_comb begin
    sel_slot = slot_q[lk_idx];
    sel_odd  = lk_va[PAGE_SHIFT];
    for (int i = 0; i < MASK_W; i++) begin
      if (sel_slot.mask[i]) sel_odd = lk_va[PAGE_SHIFT+1+i];
    end
    half = sel_odd ? sel_slot.odd : sel_slot.even;

    off_mask                      = '0;
    off_mask[PAGE_SHIFT-1:0]      = '1;
    off_mask[PAGE_SHIFT +: MASK_W] = sel_slot.mask;
    pa_raw = {half.pfn, {PAGE_SHIFT{1'b0}}} | (lk_va[PA_W-1:0] & off_mask);

    status_d = ST_HIT;
    pa_d     = '0;
    cattr_d  = '0;
    if (!lk_any)                       status_d = ST_MISS;
    else if (!half.valid)              status_d = ST_INVALID;
    else if (lk_store && !half.dirty)  status_d = ST_MODIFY;
    else begin
      pa_d    = pa_raw;
      cattr_d = half.cattr;
    end

    pr_res_d = pr_any ? {1'b0, pr_idx} : {1'b1, {IDX_W{1'b0}}};
  end

  // result registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lk_valid  <= 1'b0;
      lk_status <= '0;
      lk_pa     <= '0;
      lk_cattr  <= '0;
      lk_index  <= '0;
      pr_valid  <= 1'b0;
      pr_result <= '0;
    end else begin
      lk_valid <= lk_req;
      pr_valid <= pr_req;
      if (lk_req) begin
        lk_status <= status_d;
        lk_pa     <= pa_d;
        lk_cattr  <= cattr_d;
        lk_index  <= lk_idx;
      end
      if (pr_req) begin
        pr_result <= pr_res_d;
      end
    end
  end
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter int IDX_W = 3,
  parameter int PA_W  = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic             lk_store,
  input logic             lk_valid,
  input logic [1:0]       lk_status,
  input logic [PA_W-1:0]  lk_pa,
  input logic [2:0]       lk_cattr,
  input logic             pr_req,
  input logic             pr_valid,
  input logic [IDX_W:0]   pr_result
);
  p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_valid);

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_status != 2'd0) |-> (lk_pa == '0 && lk_cattr == 3'd0));

  p_load_nomod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_store) |=> (lk_status != 2'd3));

  p_probe_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pr_req |=> pr_valid);

  p_probe_fmt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && pr_result[IDX_W]) |-> (pr_result[IDX_W-1:0] == '0));
endmodule

bind pair_tlb pair_tlb_chk #(.IDX_W(IDX_W), .PA_W(pair_tlb_pkg::PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_req    (lk_req),
  .lk_store  (lk_store),
  .lk_valid  (lk_valid),
  .lk_status (lk_status),
  .lk_pa     (lk_pa),
  .lk_cattr  (lk_cattr),
  .pr_req    (pr_req),
  .pr_valid  (pr_valid),
  .pr_result (pr_result)
);

// File: tb/pair_tlb_tb.sv
module pair_tlb_tb;
  localparam int N = 8;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_index = '0;
  logic [63:0] wr_hi = '0;
  logic [3:0]  wr_mask = '0;
  logic [31:0] wr_lo0 = '0, wr_lo1 = '0;
  logic        lk_req = 1'b0;
  logic [63:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_store = 1'b0;
  logic        lk_valid;
  logic [1:0]  lk_status;
  logic [35:0] lk_pa;
  logic [2:0]  lk_cattr;
  logic [2:0]  lk_index;
  logic        pr_req = 1'b0;
  logic [63:0] pr_hi = '0;
  logic        pr_valid;
  logic [3:0]  pr_result;

  always #(CLK_P/2) clk = ~clk;

  pair_tlb u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_hi   [N];
  logic [3:0]  m_mask [N];
  logic [31:0] m_lo0  [N];
  logic [31:0] m_lo1  [N];

  function automatic void check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] mk_lo(logic [23:0] pfn, logic [2:0] c,
                                        logic d, logic v, logic g);
    return {2'b00, pfn, c, d, v, g};
  endfunction

  function automatic bit slot_hit(int i, logic [63:0] va, logic [7:0] asid);
    if (m_hi[i][63:62] != va[63:62]) return 0;
    for (int b = 13; b <= 39; b++) begin
      if (b - 13 < 4) begin
        if (m_mask[i][b-13]) continue;
      end
      if (m_hi[i][b] != va[b]) return 0;
    end
    if (!(m_lo0[i][0] & m_lo1[i][0]) && m_hi[i][7:0] != asid) return 0;
    return 1;
  endfunction

  function automatic void exp_lookup(input logic [63:0] va, input logic [7:0] asid,
      input logic store, output logic [1:0] st, output logic [35:0] pa,
      output logic [2:0] c, output logic [2:0] idx);
    int hit_i = -1;
    int cnt;
    logic [31:0] lo;
    for (int i = N - 1; i >= 0; i--) if (slot_hit(i, va, asid)) hit_i = i;
    pa = '0; c = '0; idx = '0;
    if (hit_i < 0) st = 2'd1;
    else begin
      idx = hit_i[2:0];
      cnt = $countones(m_mask[hit_i]);
      lo  = va[12+cnt] ? m_lo1[hit_i] : m_lo0[hit_i];
      if (!lo[1]) st = 2'd2;
      else if (store && !lo[2]) st = 2'd3;
      else begin
        st = 2'd0;
        pa = ({12'b0, lo[29:6]} << 12) | (va[35:0] & ((36'd1 << (12 + cnt)) - 36'd1));
        c  = lo[5:3];
      end
    end
  endfunction

  function automatic logic [3:0] exp_probe(logic [63:0] hi);
    for (int i = 0; i < N; i++) if (slot_hit(i, hi, hi[7:0])) return {1'b0, 3'(i)};
    return 4'b1000;
  endfunction

  task automatic write_slot(logic [2:0] idx, logic [63:0] hi, logic [3:0] mask,
                            logic [31:0] lo0, logic [31:0] lo1);
    @(negedge clk);
    wr_en = 1; wr_index = idx; wr_hi = hi; wr_mask = mask; wr_lo0 = lo0; wr_lo1 = lo1;
    @(negedge clk);
    wr_en = 0;
    m_hi[idx] = hi; m_mask[idx] = mask; m_lo0[idx] = lo0; m_lo1[idx] = lo1;
  endtask

  task automatic lookup(string tag, logic [63:0] va, logic [7:0] asid, logic store);
    logic [1:0] st; logic [35:0] pa; logic [2:0] c, idx;
    @(negedge clk);
    lk_req = 1; lk_va = va; lk_asid = asid; lk_store = store;
    exp_lookup(va, asid, store, st, pa, c, idx);
    @(negedge clk);
    lk_req = 0;
    check({tag, " R2 valid"}, 64'(lk_valid), 64'd1);
    check({tag, " status"}, 64'(lk_status), 64'(st));
    check({tag, " pa"}, 64'(lk_pa), 64'(pa));
    check({tag, " cattr"}, 64'(lk_cattr), 64'(c));
    if (st != 2'd1) check({tag, " R8 index"}, 64'(lk_index), 64'(idx));
  endtask

  task automatic probe(string tag, logic [63:0] hi);
    logic [3:0] e;
    @(negedge clk);
    pr_req = 1; pr_hi = hi;
    e = exp_probe(hi);
    @(negedge clk);
    pr_req = 0;
    check({tag, " R9 probe valid"}, 64'(pr_valid), 64'd1);
    check({tag, " R9 probe"}, 64'(pr_result), 64'(e));
  endtask

  function automatic logic [63:0] rnd_va();
    logic [63:0] v;
    v = {$urandom, $urandom};
    v[63:62] = ($urandom % 2) ? 2'b11 : 2'b00;
    v[39:14] = 26'($urandom % 4);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] va0, gva;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_hi[i] = '0; m_mask[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 lk_valid", 64'(lk_valid), 64'd0);
    check("R1 pr_valid", 64'(pr_valid), 64'd0);
    check("R1 lk_pa", 64'(lk_pa), 64'd0);
    lookup("R1 zero slot", 64'h0, 8'h00, 1'b0);
    check("R1 invalid code", 64'(lk_status), 64'd2);
    lookup("R1 outside", 64'h0000_0000_0012_4000, 8'h00, 1'b0);
    check("R1 miss code", 64'(lk_status), 64'd1);
    @(negedge clk);
    check("R2 valid drops", 64'(lk_valid), 64'd0);

    // R4 R6 R7 basic pair
    va0 = 64'h0000_0012_3456_0000;
    write_slot(3'd1, va0 | 64'h1F05, 4'h0,
               mk_lo(24'h00ABC, 3'd3, 1'b1, 1'b1, 1'b0) | 32'hC000_0000,
               mk_lo(24'h00DEF, 3'd2, 1'b0, 1'b1, 1'b0));
    lookup("R4 even", va0 | 64'h0765, 8'h05, 1'b0);
    check("R6 even pa", 64'(lk_pa), 64'h00ABC765);
    lookup("R4 odd", va0 | 64'h1765, 8'h05, 1'b0);
    check("R6 odd attr", 64'(lk_cattr), 64'd2);
    lookup("R7 store clean", va0 | 64'h1004, 8'h05, 1'b1);
    check("R7 modify code", 64'(lk_status), 64'd3);
    lookup("R7 store dirty", va0 | 64'h0004, 8'h05, 1'b1);
    lookup("R3 asid mismatch", va0, 8'h06, 1'b0);
    check("R3 miss", 64'(lk_status), 64'd1);
    lookup("R3 region", va0 | 64'hC000_0000_0000_0000, 8'h05, 1'b0);
    lookup("R11 fill bits", va0 | 64'h3FFF_FF00_0000_0000, 8'h05, 1'b0);
    check("R11 hit", 64'(lk_status), 64'd0);

    // R3 global needs both bits
    gva = 64'hC000_0000_0777_0000;
    write_slot(3'd2, gva | 64'h11, 4'h0,
               mk_lo(24'h1, 3'd3, 1'b1, 1'b1, 1'b1), mk_lo(24'h2, 3'd3, 1'b1, 1'b1, 1'b1));
    lookup("R3 global", gva, 8'h99, 1'b0);
    check("R3 global hit", 64'(lk_status), 64'd0);
    write_slot(3'd2, gva | 64'h11, 4'h0,
               mk_lo(24'h1, 3'd3, 1'b1, 1'b1, 1'b1), mk_lo(24'h2, 3'd3, 1'b1, 1'b1, 1'b0));
    lookup("R3 half global", gva, 8'h99, 1'b0);
    check("R3 half global miss", 64'(lk_status), 64'd1);

    // R7 invalid half
    write_slot(3'd4, 64'h0000_0000_0040_0000 | 64'h07, 4'h0,
               mk_lo(24'h3, 3'd3, 1'b1, 1'b0, 1'b0), mk_lo(24'h4, 3'd3, 1'b1, 1'b1, 1'b0));
    lookup("R7 invalid", 64'h0000_0000_0040_0123, 8'h07, 1'b0);
    check("R7 invalid code", 64'(lk_status), 64'd2);

    // R8 duplicates
    write_slot(3'd6, 64'h0000_0000_0080_0009, 4'h0,
               mk_lo(24'h66, 3'd3, 1'b1, 1'b1, 1'b0), mk_lo(24'h66, 3'd3, 1'b1, 1'b1, 1'b0));
    write_slot(3'd3, 64'h0000_0000_0080_0009, 4'h0,
               mk_lo(24'h33, 3'd3, 1'b1, 1'b1, 1'b0), mk_lo(24'h33, 3'd3, 1'b1, 1'b1, 1'b0));
    lookup("R8 lowest", 64'h0000_0000_0080_0010, 8'h09, 1'b0);
    check("R8 index 3", 64'(lk_index), 64'd3);

    // R5 mask: 16K pages, select bit 13
    write_slot(3'd5, 64'h0000_0000_0100_0002, 4'h1,
               mk_lo(24'h500, 3'd3, 1'b1, 1'b1, 1'b0), mk_lo(24'h900, 3'd3, 1'b1, 1'b1, 1'b0));
    lookup("R5 mask even", 64'h0000_0000_0100_1ABC, 8'h02, 1'b0);
    check("R5 offset through", 64'(lk_pa), 64'h00501ABC);
    lookup("R5 mask odd", 64'h0000_0000_0100_3ABC, 8'h02, 1'b0);
    check("R5 odd pa", 64'(lk_pa), 64'h00901ABC);

    // R9 probe
    probe("R9 hit", 64'h0000_0000_0080_0009);
    probe("R9 none", 64'h0000_0000_0ABC_0009);
    probe("R9 invalid slot", 64'h0000_0000_0040_0007);

    // R10 write and lookup in the same cycle
    begin
      logic [1:0] st; logic [35:0] pa; logic [2:0] c, idx;
      @(negedge clk);
      exp_lookup(va0, 8'h05, 1'b0, st, pa, c, idx);
      wr_en = 1; wr_index = 3'd1; wr_hi = 64'h0000_0000_0F00_0001; wr_mask = 4'h0;
      wr_lo0 = mk_lo(24'h7, 3'd3, 1'b1, 1'b1, 1'b0); wr_lo1 = wr_lo0;
      lk_req = 1; lk_va = va0; lk_asid = 8'h05; lk_store = 0;
      @(negedge clk);
      wr_en = 0; lk_req = 0;
      m_hi[1] = wr_hi; m_mask[1] = 4'h0; m_lo0[1] = wr_lo0; m_lo1[1] = wr_lo1;
      check("R10 old contents", 64'(lk_pa), 64'(pa));
      lookup("R10 new contents", va0, 8'h05, 1'b0);
      check("R10 now miss", 64'(lk_status), 64'd1);
    end

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 4;
      if (op == 0) begin
        logic [63:0] h = rnd_va();
        h[7:0] = 8'($urandom % 2 + 1);
        write_slot(3'($urandom), h, ($urandom % 4 == 0) ? 4'h1 : 4'h0,
                   {$urandom} & 32'hFFFF_FFF7 | (($urandom % 4 == 0) ? 32'h0 : 32'h0) ,
                   {$urandom});
      end else if (op == 3) begin
        logic [63:0] h = rnd_va();
        h[7:0] = 8'($urandom % 2 + 1);
        probe("R9 random", h);
      end else begin
        lookup("R3 random", rnd_va(), 8'($urandom % 2 + 1), 1'($urandom));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule